// File: doc/BRIEF.md
# I2C Slave Controller with Input Debounce

This block is a slave-only I2C controller. It watches the two bus lines, and when a START is followed by an address byte whose upper seven bits equal the programmed own address, it takes part in the transfer. The direction comes from the eighth bit of the address byte. On a write from the master the block receives bytes. On a read it transmits bytes. Every byte passes through a single data register. Software reads that register after a byte arrives, and it loads the register before each byte goes out.

Both bus inputs first pass through a filter that runs on the system clock. The filter accepts a level change only after the new level has held for a selectable number of clocks, so short glitches are removed before START, STOP or bit detection. The block never drives a bus line high. It only asserts a pull-low request for each line, and the external pull-ups do the rest. After each completed byte the block keeps SCL low until software has serviced the data register. A pending flag tells software that service is due.

Top module: `i2c_slave_filt`

## Requirements
- R1: The outputs `sdaDrvLow` and `sclDrvLow` mean "pull the line low" when 1 and "release" when 0. After reset both are 0, and the bus lines are never driven high.
- R2: A START (SDA falling while SCL is high) sets `busy` to 1, and a STOP (SDA rising while SCL is high) clears it. Both are detected on the filtered lines, and a repeated START restarts address reception.
- R3: An address byte is taken MSB first on SCL rising edges. Bits 7..1 are compared with `ownAddr`, and bit 0 gives the direction (1 = slave transmits). On a match the block pulls SDA low during the ninth clock and sets `addressed`, and `slaveTx` takes the value of bit 0.
- R4: When the address bits differ from `ownAddr`, SDA is left released in the ninth clock, `addressed` stays 0 and no byte becomes pending.
- R5: In receive mode each 8-bit data byte, MSB first, is copied into the data register (`dataOut`). The block acknowledges it by pulling SDA low in the ninth clock, and `bytePending` is set.
- R6: In transmit mode the data register content is sent MSB first. SDA changes only while SCL is low.
- R7: In transmit mode, a NACK (SDA high) from the master in the ninth clock makes the block release SDA and clear `addressed`. It then ignores the bus until the next START.
- R8: While a byte is pending (after a received byte, after a read address, or after an acknowledged transmitted byte), SCL is held low. A one-cycle `rdEn` or `wrEn` pulse clears `bytePending` and lets SCL go.
- R9: `dbSel` gives the filter length N: 0 means none, 1 means one clock, and 2 or 3 mean two clocks. A line level that lasts N or fewer system clocks is ignored, and a level that lasts N+1 clocks is accepted.
- R10: While `enable` is 0 the block drives neither line, does not acknowledge any address, and keeps `busy`, `addressed` and `bytePending` at 0.
- R11: A STOP returns the block to idle and clears `addressed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; when 0 the bus is ignored |
| dbSel | input | 2 | Debounce length select (0, 1, 2; 3 acts as 2) |
| ownAddr | input | 7 | Own slave address |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclDrvLow | output | 1 | Pull SCL low when 1 |
| sdaDrvLow | output | 1 | Pull SDA low when 1 |
| wrEn | input | 1 | Software write strobe for the data register |
| wrData | input | 8 | Byte written by software |
| rdEn | input | 1 | Software read acknowledge strobe |
| dataOut | output | 8 | Data register content |
| busy | output | 1 | Bus is between START and STOP |
| addressed | output | 1 | Block has been selected by its address |
| slaveTx | output | 1 | Direction: 1 = slave transmits |
| bytePending | output | 1 | A byte waits for software service |

## Verification
In transmit mode one software write does two jobs: it ends the SCL hold, and it sets up the first data bit on SDA. If both took effect in the same cycle, the bus could see an SDA change at the moment SCL rises, which is a false START or STOP. The bench provokes this by having the master release SCL before the write arrives, so the master waits on a held line while software writes late. The result is judged by two things: the master must read the correct bytes, and `busy` must stay 1 until the real STOP.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX_WAIT,
    ST_TX_LOAD,
    ST_TX,
    ST_TX_ACK
  } slvState_t;

  // Events seen on the filtered bus lines
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
  } busEv_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearShift;
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic captureRx;
  } dpStrobe_t;

endpackage

// File: rtl/i2cs_filter.sv
module i2cs_filter #(
  parameter int SEL_W   = 2,
  parameter int MAX_SEL = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] dbSel,
  input  logic             rawIn,
  output logic             filtOut
);

  logic             rawQ;
  logic [SEL_W-1:0] runLen;
  logic [SEL_W-1:0] limit;

  always_comb begin
    limit = (dbSel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : dbSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ    <= 1'b1;
      filtOut <= 1'b1;
      runLen  <= '0;
    end else begin
      rawQ <= rawIn;
      if (rawQ == filtOut) begin
        runLen <= '0;
      end else if (runLen == limit) begin
        filtOut <= rawQ;
        runLen  <= '0;
      end else begin
        runLen <= runLen + 1'b1;
      end
    end
  end

  // R9
  filt_follows_raw_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtOut) |-> (filtOut == $past(rawQ)));

endmodule

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclF,
  input  logic              sdaF,
  input  dpStrobe_t         stb,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] ownAddr,
  output busEv_t            ev,
  output logic              addrHit,
  output logic              rwBit,
  output logic              txBit,
  output logic [DATA_W-1:0] dataOut
);

  logic              sclPrev;
  logic              sdaPrev;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  always_comb begin
    ev.sclRise = sclF & ~sclPrev;
    ev.sclFall = ~sclF & sclPrev;
    ev.start   = sclF & sclPrev & sdaPrev & ~sdaF;
    ev.stop    = sclF & sclPrev & ~sdaPrev & sdaF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.clearShift) begin
      shiftReg <= '0;
    end else if (stb.loadTx) begin
      shiftReg <= wrData;
    end else if (stb.shiftIn) begin
      shiftReg <= {shiftReg[DATA_W-2:0], sdaF};
    end else if (stb.shiftOut) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (stb.captureRx) begin
      dataReg <= shiftReg;
    end else if (wrEn) begin
      dataReg <= wrData;
    end
  end

  assign addrHit = (shiftReg[DATA_W-1 -: ADDR_W] == ownAddr);
  assign rwBit   = shiftReg[0];
  assign txBit   = shiftReg[DATA_W-1];
  assign dataOut = dataReg;

  // R5
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.captureRx |=> (dataReg == $past(shiftReg)));

endmodule

// File: rtl/i2cs_control.sv
module i2cs_control
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  busEv_t    ev,
  input  logic      addrHit,
  input  logic      rwBit,
  input  logic      txBit,
  input  logic      sdaF,
  input  logic      wrEn,
  input  logic      rdEn,
  output dpStrobe_t stb,
  output logic      sdaDrvLow,
  output logic      sclDrvLow,
  output logic      busy,
  output logic      addressed,
  output logic      slaveTx,
  output logic      bytePending
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(DATA_W - 1);

  slvState_t        state, nState;
  logic [CNT_W-1:0] bitCnt, nCnt;
  logic             masterAck, nAck;
  logic             nAddressed, nSlaveTx, setPend;

  always_comb begin
    nState     = state;
    nCnt       = bitCnt;
    nAck       = masterAck;
    nAddressed = addressed;
    nSlaveTx   = slaveTx;
    setPend    = 1'b0;
    stb        = '0;
    if (ev.stop) begin
      nState     = ST_IDLE;
      nAddressed = 1'b0;
    end else if (ev.start) begin
      nState         = ST_ADDR;
      nCnt           = '0;
      nAddressed     = 1'b0;
      stb.clearShift = 1'b1;
    end else begin
      case (state)
        ST_ADDR: begin
          if (ev.sclRise) begin
            stb.shiftIn = 1'b1;
            nCnt        = bitCnt + 1'b1;
          end else if (ev.sclFall && bitCnt == LAST_BIT) begin
            if (addrHit) begin
              nState     = ST_ADDR_ACK;
              nAddressed = 1'b1;
              nSlaveTx   = rwBit;
            end else begin
              nState = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (ev.sclFall) begin
            if (slaveTx) begin
              nState  = ST_TX_WAIT;
              setPend = 1'b1;
            end else begin
              nState = ST_RX;
              nCnt   = '0;
            end
          end
        end
        ST_RX: begin
          if (ev.sclRise) begin
            stb.shiftIn = 1'b1;
            nCnt        = bitCnt + 1'b1;
          end else if (ev.sclFall && bitCnt == LAST_BIT) begin
            stb.captureRx = 1'b1;
            setPend       = 1'b1;
            nState        = ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (ev.sclFall) begin
            nState = ST_RX;
            nCnt   = '0;
          end
        end
        ST_TX_WAIT: begin
          if (wrEn) begin
            stb.loadTx = 1'b1;
            nState     = ST_TX_LOAD;
          end
        end
        ST_TX_LOAD: begin
          nState = ST_TX;
          nCnt   = '0;
        end
        ST_TX: begin
          if (ev.sclFall) begin
            nCnt = bitCnt + 1'b1;
            if (bitCnt == LAST_TX) begin
              nState = ST_TX_ACK;
            end else begin
              stb.shiftOut = 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (ev.sclRise) begin
            nAck = ~sdaF;
          end else if (ev.sclFall) begin
            if (masterAck) begin
              nState  = ST_TX_WAIT;
              setPend = 1'b1;
            end else begin
              nState     = ST_IDLE;
              nAddressed = 1'b0;
            end
          end
        end
        default: nState = ST_IDLE;
      endcase
    end
    if (!enable) begin
      stb = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      masterAck   <= 1'b0;
      addressed   <= 1'b0;
      slaveTx     <= 1'b0;
      busy        <= 1'b0;
      bytePending <= 1'b0;
    end else if (!enable) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      masterAck   <= 1'b0;
      addressed   <= 1'b0;
      slaveTx     <= 1'b0;
      busy        <= 1'b0;
      bytePending <= 1'b0;
    end else begin
      state       <= nState;
      bitCnt      <= nCnt;
      masterAck   <= nAck;
      addressed   <= nAddressed;
      slaveTx     <= nSlaveTx;
      if (ev.start) begin
        busy <= 1'b1;
      end else if (ev.stop) begin
        busy <= 1'b0;
      end
      bytePending <= setPend | (bytePending & ~(wrEn | rdEn));
    end
  end

  always_comb begin
    sdaDrvLow = (state == ST_ADDR_ACK) || (state == ST_RX_ACK) ||
                (((state == ST_TX_LOAD) || (state == ST_TX)) && !txBit);
    sclDrvLow = (state == ST_TX_LOAD) ||
                (bytePending && ((state == ST_RX_ACK) || (state == ST_TX_WAIT)));
  end

  // R2
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && ev.start) |=> busy);

  // R11
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && ev.stop) |=> (!addressed && !busy));

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sdaDrvLow && !sclDrvLow && !busy && !bytePending));

  // R4
  addr_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && state == ST_ADDR && ev.sclFall && !ev.start && !ev.stop &&
     bitCnt == LAST_BIT && !addrHit) |=> (!addressed && !sdaDrvLow));

  // R8
  hold_needs_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclDrvLow |-> addressed);

endmodule

// File: rtl/i2c_slave_filt.sv
module i2c_slave_filt
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [SEL_W-1:0]  dbSel,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDrvLow,
  output logic              sdaDrvLow,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] dataOut,
  output logic              busy,
  output logic              addressed,
  output logic              slaveTx,
  output logic              bytePending
);

  localparam int N_LINES = 2;

  logic [N_LINES-1:0] rawLines;
  logic [N_LINES-1:0] filtLines;
  logic               sclF, sdaF;
  busEv_t             ev;
  dpStrobe_t          stb;
  logic               addrHit, rwBit, txBit;

  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    i2cs_filter #(.SEL_W(SEL_W)) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .dbSel  (dbSel),
      .rawIn  (rawLines[g]),
      .filtOut(filtLines[g])
    );
  end

  assign sclF = filtLines[1];
  assign sdaF = filtLines[0];

  i2cs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .sclF   (sclF),
    .sdaF   (sdaF),
    .stb    (stb),
    .wrEn   (wrEn),
    .wrData (wrData),
    .ownAddr(ownAddr),
    .ev     (ev),
    .addrHit(addrHit),
    .rwBit  (rwBit),
    .txBit  (txBit),
    .dataOut(dataOut)
  );

  i2cs_control #(.DATA_W(DATA_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .ev         (ev),
    .addrHit    (addrHit),
    .rwBit      (rwBit),
    .txBit      (txBit),
    .sdaF       (sdaF),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .stb        (stb),
    .sdaDrvLow  (sdaDrvLow),
    .sclDrvLow  (sclDrvLow),
    .busy       (busy),
    .addressed  (addressed),
    .slaveTx    (slaveTx),
    .bytePending(bytePending)
  );

  // R6
  sda_moves_on_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDrvLow) |-> !sclF);

endmodule

// File: tb/i2c_slave_filt_test.sv
module i2c_slave_filt_test;

  localparam int HALF = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b1;
  logic [1:0] dbSel = 2'd1;
  logic [6:0] ownAddr = 7'h2A;
  logic       mSclLow = 1'b0;
  logic       mSdaLow = 1'b0;
  logic       sclLine, sdaLine;
  logic       sclDrvLow, sdaDrvLow;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] dataOut;
  logic       busy, addressed, slaveTx, bytePending;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;

  logic [7:0] rxExp[$];
  logic [7:0] txFeed[$];
  logic [7:0] txExp[$];

  always #10 clk = ~clk;

  assign sclLine = !(mSclLow | sclDrvLow);
  assign sdaLine = !(mSdaLow | sdaDrvLow);

  i2c_slave_filt uut (
    .clk(clk), .rstN(rstN), .enable(enable), .dbSel(dbSel), .ownAddr(ownAddr),
    .sclIn(sclLine), .sdaIn(sdaLine), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .dataOut(dataOut),
    .busy(busy), .addressed(addressed), .slaveTx(slaveTx), .bytePending(bytePending)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockPulse(output logic s);
    mSclLow = 1'b0;
    while (!sclLine) @(negedge clk);
    waitClk(HALF / 2);
    s = sdaLine;
    waitClk(HALF / 2);
    mSclLow = 1'b1;
    waitClk(HALF / 2);
  endtask

  task automatic startCond();
    mSdaLow = 1'b0;
    waitClk(HALF / 2);
    mSclLow = 1'b0;
    while (!sclLine) @(negedge clk);
    waitClk(HALF);
    mSdaLow = 1'b1;
    waitClk(HALF);
    mSclLow = 1'b1;
    waitClk(HALF / 2);
  endtask

  task automatic stopCond();
    mSdaLow = 1'b1;
    waitClk(HALF / 2);
    mSclLow = 1'b0;
    while (!sclLine) @(negedge clk);
    waitClk(HALF);
    mSdaLow = 1'b0;
    waitClk(HALF);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      mSdaLow = !b[i];
      waitClk(HALF / 2);
      clockPulse(s);
    end
    mSdaLow = 1'b0;
    waitClk(HALF / 2);
    clockPulse(s);
    ack = !s;
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] b);
    logic s;
    mSdaLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitClk(HALF / 2);
      clockPulse(s);
      b[i] = s;
    end
    mSdaLow = ackIt;
    waitClk(HALF / 2);
    clockPulse(s);
    mSdaLow = 1'b0;
  endtask

  // driver side of the scoreboard: master write of data bytes
  task automatic sendBytes(input logic [6:0] addr, input logic [7:0] d0, input logic [7:0] d1);
    logic ack;
    startCond();
    checkEq("R2 busy after START", busy, 1);
    writeByte({addr, 1'b0}, ack);
    checkEq("R3 address ACK on write", ack, 1);
    checkEq("R3 addressed after match", addressed, 1);
    checkEq("R3 direction receive", slaveTx, 0);
    rxExp.push_back(d0);
    writeByte(d0, ack);
    checkEq("R5 data ACK byte 0", ack, 1);
    rxExp.push_back(d1);
    writeByte(d1, ack);
    checkEq("R5 data ACK byte 1", ack, 1);
    stopCond();
    waitClk(6);
    checkEq("R11 addressed cleared by STOP", addressed, 0);
    checkEq("R2 busy cleared by STOP", busy, 0);
  endtask

  task automatic glitch(input int k, output logic sawBusy);
    sawBusy = 1'b0;
    mSdaLow = 1'b1;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      sawBusy = sawBusy | busy;
    end
    mSdaLow = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      sawBusy = sawBusy | busy;
    end
  endtask

  // monitor / software side: services the data register and pops expectations
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && bytePending) begin
        waitClk(20);
        checkEq("R8 SCL held while byte pending", sclDrvLow, 1);
        checkEq("R8 SCL line low while pending", sclLine, 0);
        if (slaveTx) begin
          if (txFeed.size() == 0) begin
            checkEq("R6 transmit byte available", 0, 1);
            wrData = 8'h00;
          end else begin
            wrData = txFeed.pop_front();
          end
          wrEn = 1'b1;
          @(negedge clk);
          wrEn = 1'b0;
        end else begin
          if (rxExp.size() == 0) begin
            checkEq("R5 unexpected received byte", {24'd0, dataOut}, 32'hFFFF_FFFF);
          end else begin
            checkEq("R5 received byte in data register", {24'd0, dataOut}, {24'd0, rxExp.pop_front()});
          end
          rdEn = 1'b1;
          @(negedge clk);
          rdEn = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic       ack, s, saw;
    logic [7:0] rb;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    checkEq("R1 SDA released after reset", sdaDrvLow, 0);
    checkEq("R1 SCL released after reset", sclDrvLow, 0);
    checkEq("R2 busy clear after reset", busy, 0);
    checkEq("R3 addressed clear after reset", addressed, 0);
    checkEq("R5 pending clear after reset", bytePending, 0);

    // receive path, two patterns
    sendBytes(7'h2A, 8'hA5, 8'h3C);
    sendBytes(7'h2A, 8'hFF, 8'h00);

    // address mismatch, far and one-bit-off
    for (int a = 0; a < 2; a++) begin
      startCond();
      writeByte({(a == 0) ? 7'h15 : 7'h2B, 1'b0}, ack);
      checkEq("R4 no ACK on foreign address", ack, 0);
      checkEq("R4 not addressed on mismatch", addressed, 0);
      waitClk(4);
      checkEq("R4 no pending on mismatch", bytePending, 0);
      stopCond();
    end

    // transmit path with late software write and final NACK
    txFeed.push_back(8'h96); txExp.push_back(8'h96);
    txFeed.push_back(8'h01); txExp.push_back(8'h01);
    txFeed.push_back(8'hC3); txExp.push_back(8'hC3);
    startCond();
    writeByte({7'h2A, 1'b1}, ack);
    checkEq("R3 address ACK on read", ack, 1);
    checkEq("R3 direction transmit", slaveTx, 1);
    for (int i = 0; i < 3; i++) begin
      readByte((i < 2) ? 1'b1 : 1'b0, rb);
      checkEq("R6 transmitted byte", {24'd0, rb}, {24'd0, txExp.pop_front()});
      checkEq("R6 no false STOP during transmit", busy, 1);
    end
    waitClk(4);
    checkEq("R7 SDA released after NACK", sdaDrvLow, 0);
    checkEq("R7 addressed cleared after NACK", addressed, 0);
    clockPulse(s);
    checkEq("R7 bus ignored until next START", s, 1);
    stopCond();

    // repeated START: write one byte, then read one byte
    txFeed.push_back(8'h7B);
    startCond();
    writeByte({7'h2A, 1'b0}, ack);
    rxExp.push_back(8'h5E);
    writeByte(8'h5E, ack);
    checkEq("R5 ACK before repeated START", ack, 1);
    startCond();
    checkEq("R2 busy through repeated START", busy, 1);
    writeByte({7'h2A, 1'b1}, ack);
    checkEq("R3 ACK after repeated START", ack, 1);
    readByte(1'b1 == 1'b0, rb);
    checkEq("R6 byte after repeated START", {24'd0, rb}, 32'h7B);
    stopCond();

    // disabled block ignores the bus
    enable = 1'b0;
    startCond();
    checkEq("R10 busy stays clear when disabled", busy, 0);
    writeByte({7'h2A, 1'b0}, ack);
    checkEq("R10 no ACK when disabled", ack, 0);
    checkEq("R10 not addressed when disabled", addressed, 0);
    stopCond();
    enable = 1'b1;
    waitClk(5);

    // debounce length against pulse width (fake START pulses on SDA)
    dbSel = 2'd1; waitClk(5);
    glitch(1, saw); checkEq("R9 N=1 rejects 1-clock pulse", saw, 0);
    glitch(2, saw); checkEq("R9 N=1 accepts 2-clock pulse", saw, 1);
    dbSel = 2'd2; waitClk(5);
    glitch(2, saw); checkEq("R9 N=2 rejects 2-clock pulse", saw, 0);
    glitch(3, saw); checkEq("R9 N=2 accepts 3-clock pulse", saw, 1);
    dbSel = 2'd3; waitClk(5);
    glitch(2, saw); checkEq("R9 code 3 acts as N=2", saw, 0);
    dbSel = 2'd0; waitClk(5);
    glitch(1, saw); checkEq("R9 N=0 passes 1-clock pulse", saw, 1);

    // full transfers at the other filter settings
    sendBytes(7'h2A, 8'h42, 8'hBD);
    dbSel = 2'd2; waitClk(5);
    sendBytes(7'h2A, 8'h81, 8'h7E);

    waitClk(40);
    checkEq("R5 all received bytes serviced", rxExp.size(), 0);
    checkEq("R6 all transmit bytes consumed", txFeed.size(), 0);
    checkEq("R1 lines released at end", {sclDrvLow, sdaDrvLow}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule